// File: doc/BRIEF.md
# Page-Mode DRAM Burst Read Sequencer

This block fills one four-word cache line from a page-mode DRAM. A CPU-side port presents a word address and a timing-mode select. When the sequencer is idle it accepts the request. It then opens the row that the upper half of the address names and issues column accesses for the four words of the aligned line. The burst starts at the requested word and wraps within the line. The words come back on a data port, each marked by a one-cycle valid pulse.

Three timing personalities are selectable per request:
- **Conventional fast page (6-3-3-3).** The column strobe and the DRAM output enable are withdrawn after every word.
- **Extended data out (6-2-2-2).** The DRAM output stays enabled across the burst, and a word is captured on the same edge that starts the next column.
- **Burst extended data out (5-1-1-1).** The column strobe is held low while an internal counter steps the column each clock. Every word passes through a one-stage output latch before it reaches the port.

Beat times are counted in clocks from the edge that accepts the request, which is edge 0.

Top module: `pagedram_burst_seq`

## Requirements
- R1: While reset is held, and in every idle cycle with no request, `dramRasN` and `dramCasN` are 1, `dramOe` is 0, `beatValid` is 0 and `busy` is 0.
- R2: A request (`reqValid`=1) is accepted only on an edge where `busy` is 0. `busy` rises on that edge and falls on the edge of the last beat. A request presented while `busy` is 1 is ignored and does not alter the running burst.
- R3: On the accepting edge `dramRasN` falls and `dramAddr` carries the row, `reqAddr[2*MUX_W-1:MUX_W]`. `dramRasN` stays 0 until the edge of the last beat.
- R4: The four beats return the words at columns whose upper bits are `reqAddr[MUX_W-1:2]`. The low two bits step start, start+1, start+2, start+3 modulo 4. `dramCasN` is 0 only while `dramRasN` is 0.
- R5: With `modeSel` 0 (fast page), or the unused code 3, `beatValid` is 1 in the cycles after edges 6, 9, 12 and 15.
- R6: In fast-page mode `dramCasN` is 0 and `dramOe` is 1 only in the two cycles before each beat edge. Both are released between column accesses.
- R7: With `modeSel` 1 (extended data out), beats follow edges 6, 8, 10 and 12. Each column strobe lasts one cycle and starts two edges before its beat. `dramOe` stays 1 from edge 4 until edge 12.
- R8: With `modeSel` 2 (burst extended data out), beats follow edges 5, 6, 7 and 8. `dramCasN` is held 0 from edge 3 through edge 6 with the column stepping each edge. `dramOe` is 1 from edge 3 until edge 8. Each word is latched one edge before it is presented.
- R9: `beatData` during a beat equals the word the DRAM delivered for that beat's column within the opened row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Line-fill request |
| reqAddr | input | 2*MUX_W | Word address: row in the upper half, column in the lower half |
| modeSel | input | 2 | Timing mode: 0 fast page, 1 extended data out, 2 burst extended data out, 3 as 0 |
| busy | output | 1 | High for the whole burst |
| beatValid | output | 1 | One-cycle pulse per returned word |
| beatData | output | DATA_W | Returned word |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 1 | Column strobe, active low |
| dramAddr | output | MUX_W | Multiplexed row/column address |
| dramOe | output | 1 | DRAM output enable, active high |
| dramDq | input | DATA_W | Data from the DRAM |

## Verification
Two functions of the block can fall on the same clock edge. In extended data out mode, the edge that captures a word is also the edge that strobes the next column, so the DRAM model changes its output only after that edge. A misaligned capture therefore returns the next word, and the per-beat data comparison reports it.

Likewise, the last beat, the release of `busy` and the arrival of a held request can meet. The bench keeps `reqValid` high through a whole burst while changing the address and mode mid-burst. The reference model then demands two things: the running burst is unchanged, and the next burst begins exactly one edge after the last beat, using the newer address.

// File: rtl/pdb_pkg.sv
package pdb_pkg;

  typedef enum logic [1:0] {
    MODE_FPM  = 2'd0,
    MODE_EDO  = 2'd1,
    MODE_BEDO = 2'd2
  } seqMode_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic rowLoad;    // put the row on the DRAM address
    logic colLoad;    // put the first column on the DRAM address
    logic colInc;     // step the column within the line
    logic latchLoad;  // capture DRAM data into the output latch
    logic beatLoad;   // update the returned word
    logic fromLatch;  // returned word comes from the latch
  } dpStrobe_t;

endpackage

// File: rtl/pdb_ctrl.sv
module pdb_ctrl
  import pdb_pkg::*;
#(
  parameter int BEATS      = 4,
  parameter int FP_FIRST   = 6,
  parameter int FP_GAP     = 3,
  parameter int EDO_FIRST  = 6,
  parameter int EDO_GAP    = 2,
  parameter int BEDO_FIRST = 5,
  parameter int BEDO_GAP   = 1,
  parameter int CAS_LEAD   = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic [1:0] modeSel,
  output logic      busy,
  output logic      rasN,
  output logic      casN,
  output logic      oe,
  output logic      beatValid,
  output dpStrobe_t strb
);

  localparam int FP_LAST   = FP_FIRST + (BEATS - 1) * FP_GAP;
  localparam int EDO_LAST  = EDO_FIRST + (BEATS - 1) * EDO_GAP;
  localparam int BEDO_LAST = BEDO_FIRST + (BEATS - 1) * BEDO_GAP;
  localparam int LONGEST   = (FP_LAST > EDO_LAST)
                           ? ((FP_LAST > BEDO_LAST) ? FP_LAST : BEDO_LAST)
                           : ((EDO_LAST > BEDO_LAST) ? EDO_LAST : BEDO_LAST);
  localparam int CYC_W     = $clog2(LONGEST + 2);

  seqMode_e         mode;
  seqMode_e         modeIn;
  logic [CYC_W-1:0] cyc;
  logic             accept;
  int               firstEdge;
  int               gapEdges;
  int               lastEdge;
  int               nextEdge;
  logic             casNext;
  logic             oeNext;
  logic             beatNext;

  assign accept = reqValid && !busy;

  always_comb begin
    case (modeSel)
      2'd1:    modeIn = MODE_EDO;
      2'd2:    modeIn = MODE_BEDO;
      default: modeIn = MODE_FPM;
    endcase
  end

  always_comb begin
    case (mode)
      MODE_EDO:  begin firstEdge = EDO_FIRST;  gapEdges = EDO_GAP;  end
      MODE_BEDO: begin firstEdge = BEDO_FIRST; gapEdges = BEDO_GAP; end
      default:   begin firstEdge = FP_FIRST;   gapEdges = FP_GAP;   end
    endcase
    lastEdge = firstEdge + (BEATS - 1) * gapEdges;
    nextEdge = int'(cyc) + 1;
  end

  // Schedule of the edge about to come, counted from the accepting edge
  always_comb begin
    strb      = '0;
    casNext   = 1'b0;
    beatNext  = 1'b0;
    strb.rowLoad   = accept;
    strb.fromLatch = (mode == MODE_BEDO);
    if (busy) begin
      for (int i = 0; i < BEATS; i++) begin
        automatic int n = firstEdge + i * gapEdges;
        if (nextEdge == n) begin
          beatNext      = 1'b1;
          strb.beatLoad = 1'b1;
        end
        if (mode == MODE_BEDO && nextEdge == n - 1) strb.latchLoad = 1'b1;
        if (nextEdge == n - CAS_LEAD) begin
          casNext = 1'b1;
          if (i == 0) strb.colLoad = 1'b1;
          else        strb.colInc  = 1'b1;
        end
        if (mode == MODE_FPM && nextEdge > n - CAS_LEAD && nextEdge < n) casNext = 1'b1;
      end
    end
    if (mode == MODE_FPM) oeNext = casNext;
    else oeNext = busy && (nextEdge >= firstEdge - CAS_LEAD) && (nextEdge < lastEdge);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      rasN      <= 1'b1;
      casN      <= 1'b1;
      oe        <= 1'b0;
      beatValid <= 1'b0;
      cyc       <= '0;
      mode      <= MODE_FPM;
    end else if (accept) begin
      busy      <= 1'b1;
      rasN      <= 1'b0;
      casN      <= 1'b1;
      oe        <= 1'b0;
      beatValid <= 1'b0;
      cyc       <= '0;
      mode      <= modeIn;
    end else if (busy) begin
      cyc       <= cyc + 1'b1;
      busy      <= (nextEdge != lastEdge);
      rasN      <= (nextEdge == lastEdge);
      casN      <= !casNext;
      oe        <= oeNext;
      beatValid <= beatNext;
    end else begin
      casN      <= 1'b1;
      oe        <= 1'b0;
      beatValid <= 1'b0;
    end
  end

  // R4
  cas_in_ras_chk: assert property (@(posedge clk) disable iff (!rstN)
    !casN |-> !rasN);

  // R6
  cas_with_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !casN |-> oe);

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid));

  // R2
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> beatValid);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !reqValid) |=> (casN && !oe && !beatValid && rasN));

endmodule

// File: rtl/pdb_dpath.sv
module pdb_dpath
  import pdb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MUX_W  = 8,
  parameter int BEATS  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strb,
  input  logic [2*MUX_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]    dramDq,
  output logic [MUX_W-1:0]     dramAddr,
  output logic [DATA_W-1:0]    beatData
);

  localparam int BEAT_W = $clog2(BEATS);

  logic [MUX_W-1:0]  colStart;
  logic [DATA_W-1:0] pipeLatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dramAddr <= '0;
      colStart <= '0;
    end else if (strb.rowLoad) begin
      dramAddr <= reqAddr[2*MUX_W-1:MUX_W];
      colStart <= reqAddr[MUX_W-1:0];
    end else if (strb.colLoad) begin
      dramAddr <= colStart;
    end else if (strb.colInc) begin
      dramAddr <= {dramAddr[MUX_W-1:BEAT_W], dramAddr[BEAT_W-1:0] + 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pipeLatch <= '0;
      beatData  <= '0;
    end else begin
      if (strb.latchLoad) pipeLatch <= dramDq;
      if (strb.beatLoad)  beatData  <= strb.fromLatch ? pipeLatch : dramDq;
    end
  end

  // R8
  latch_then_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchLoad |=> strb.beatLoad);

endmodule

// File: rtl/pagedram_burst_seq.sv
module pagedram_burst_seq
  import pdb_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int MUX_W      = 8,
  parameter int BEATS      = 4,
  parameter int FP_FIRST   = 6,
  parameter int FP_GAP     = 3,
  parameter int EDO_FIRST  = 6,
  parameter int EDO_GAP    = 2,
  parameter int BEDO_FIRST = 5,
  parameter int BEDO_GAP   = 1,
  parameter int CAS_LEAD   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [2*MUX_W-1:0]  reqAddr,
  input  logic [1:0]          modeSel,
  output logic                busy,
  output logic                beatValid,
  output logic [DATA_W-1:0]   beatData,
  output logic                dramRasN,
  output logic                dramCasN,
  output logic [MUX_W-1:0]    dramAddr,
  output logic                dramOe,
  input  logic [DATA_W-1:0]   dramDq
);

  dpStrobe_t strb;

  pdb_ctrl #(
    .BEATS(BEATS), .FP_FIRST(FP_FIRST), .FP_GAP(FP_GAP),
    .EDO_FIRST(EDO_FIRST), .EDO_GAP(EDO_GAP),
    .BEDO_FIRST(BEDO_FIRST), .BEDO_GAP(BEDO_GAP), .CAS_LEAD(CAS_LEAD)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .modeSel(modeSel),
    .busy(busy), .rasN(dramRasN), .casN(dramCasN), .oe(dramOe),
    .beatValid(beatValid), .strb(strb)
  );

  pdb_dpath #(
    .DATA_W(DATA_W), .MUX_W(MUX_W), .BEATS(BEATS)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .dramDq(dramDq), .dramAddr(dramAddr), .beatData(beatData)
  );

endmodule

// File: tb/pagedram_burst_seq_tb.sv
module pagedram_burst_seq_tb;

  localparam int DW = 16;
  localparam int MW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [2*MW-1:0] reqAddr = '0;
  logic [1:0]    modeSel = 2'd0;
  logic          busy, beatValid, dramRasN, dramCasN, dramOe;
  logic [DW-1:0] beatData, dramDq;
  logic [MW-1:0] dramAddr;

  always #2 clk = ~clk;  // 250 MHz

  pagedram_burst_seq u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .modeSel(modeSel), .busy(busy), .beatValid(beatValid), .beatData(beatData),
    .dramRasN(dramRasN), .dramCasN(dramCasN), .dramAddr(dramAddr),
    .dramOe(dramOe), .dramDq(dramDq)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  function automatic logic [DW-1:0] memWord(logic [MW-1:0] r, logic [MW-1:0] c);
    int v;
    v = int'(r) * 97 + int'(c) * 13 + 90;
    return v[DW-1:0];
  endfunction

  // DRAM behavioural model: row on RAS fall, word on each column access
  logic [MW-1:0] mRow;
  logic [DW-1:0] mHold = '0;
  logic          mRasPrev = 1'b1;
  always @(negedge clk) begin
    if (!dramRasN && mRasPrev) mRow = dramAddr;
    else if (!dramRasN && !dramCasN) mHold = memWord(mRow, dramAddr);
    mRasPrev = dramRasN;
  end
  assign dramDq = dramOe ? mHold : '0;

  // Reference model: edges since the accepting edge
  int            since = 1000;
  int            mMode = 0;
  logic [2*MW-1:0] mAddr;

  function automatic int firstOf(int m);
    return (m == 2) ? 5 : 6;
  endfunction
  function automatic int gapOf(int m);
    return (m == 1) ? 2 : ((m == 2) ? 1 : 3);
  endfunction
  function automatic int lastOf(int m);
    return firstOf(m) + 3 * gapOf(m);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rstN) since = 1000;
    else if (reqValid && !(since < lastOf(mMode))) begin
      since = 0;
      mMode = (modeSel == 2'd3) ? 0 : int'(modeSel);
      mAddr = reqAddr;
    end else if (since < 1000) since++;
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Per-cycle comparison, sampled at the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      automatic int  f = firstOf(mMode);
      automatic int  g = gapOf(mMode);
      automatic int  last = lastOf(mMode);
      automatic bit  fpm = (mMode == 0);
      automatic bit  expBeat = 1'b0;
      automatic bit  expCas = 1'b0;
      automatic bit  expOe;
      automatic int  idx = 0;
      for (int i = 0; i < 4; i++) begin
        automatic int n = f + i * g;
        if (since == n) begin expBeat = 1'b1; idx = i; end
        if (since == n - 2 || (fpm && since == n - 1)) expCas = 1'b1;
      end
      expOe = fpm ? expCas : (since >= f - 2 && since < last);
      check(busy == (since < last), "R2 busy", busy, since < last);
      check(dramRasN == !(since < last), "R3 ras", dramRasN, !(since < last));
      check(beatValid == expBeat,
            (mMode == 1) ? "R7 beat" : ((mMode == 2) ? "R8 beat" : "R5 beat"),
            beatValid, expBeat);
      check(dramCasN == !expCas, fpm ? "R6 cas" : ((mMode == 1) ? "R7 cas" : "R8 cas"),
            dramCasN, !expCas);
      check(dramOe == expOe, fpm ? "R6 oe" : ((mMode == 1) ? "R7 oe" : "R8 oe"),
            dramOe, expOe);
      check(!(!dramCasN && dramRasN), "R4 cas under ras", dramCasN, 1);
      if (since == 0)
        check(dramAddr == mAddr[2*MW-1:MW], "R3 row addr", dramAddr, mAddr[2*MW-1:MW]);
      if (expBeat) begin
        automatic logic [MW-1:0] col;
        col = {mAddr[MW-1:2], 2'(mAddr[1:0] + 2'(idx))};
        check(beatData == memWord(mAddr[2*MW-1:MW], col), "R4 R9 data",
              beatData, memWord(mAddr[2*MW-1:MW], col));
      end
    end
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      finishRun();
    end
  end

  task automatic waitAccept();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (since != 0 && guard < 100);
  endtask

  task automatic issue(int m, logic [2*MW-1:0] a);
    @(negedge clk);
    reqValid = 1'b1;
    modeSel  = 2'(m);
    reqAddr  = a;
    waitAccept();
    reqValid = 1'b0;
    repeat (lastOf(mMode) + 3) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    check(dramRasN && dramCasN, "R1 strobes", {dramRasN, dramCasN}, 3);
    check(!dramOe && !beatValid && !busy, "R1 quiet", {dramOe, beatValid, busy}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(dramRasN && dramCasN && !dramOe && !beatValid && !busy, "R1 idle",
          {dramRasN, dramCasN, dramOe, beatValid, busy}, 5'b11000);

    issue(0, 16'h3A10);  // R5 fast page, start word 0
    issue(1, 16'h5C26);  // R7 extended data out, wraps from word 2
    issue(2, 16'h7F0F);  // R8 burst mode, wraps from word 3
    issue(3, 16'h1235);  // R5 code 3 behaves as fast page
    issue(0, 16'h00FE);

    // R2: request held through a burst; mid-burst changes ignored
    @(negedge clk);
    reqValid = 1'b1;
    modeSel  = 2'd2;
    reqAddr  = 16'hA4C1;
    waitAccept();
    @(negedge clk);
    reqAddr  = 16'h6B92;
    modeSel  = 2'd1;
    waitAccept();
    reqValid = 1'b0;
    repeat (20) @(negedge clk);

    issue(2, 16'hFFFF);
    repeat (5) @(negedge clk);
    finishRun();
  end

endmodule